// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the purely combinational arithmetic and logic unit of a small accumulator-style processor. Each cycle the surrounding datapath presents an operation code, the accumulator, one index register, an operand byte and the four current status flags. The unit returns a data byte and the updated flag nibble in the same cycle. Registers, instruction decode, memory access and decimal arithmetic belong to the surrounding datapath, not to this block.

Every operation that produces a value routes its arithmetic through one shared carry adder, whose inputs are steered by the operation code. Logic operations, bit tests and the shift/rotate group run in their own small units. Any flag that an operation does not define is copied from the input flags unchanged. For compare-type operations the output byte repeats the register that was compared, so the caller can write the result back without any effect.

Top module: `alu8_core`

## Requirements
- R1: The flag nibble is packed as bit 3 = N, bit 2 = V, bit 1 = Z, bit 0 = C on both `flags_i` and `flags_o`. Operation codes are 0 AND, 1 OR, 2 XOR, 3 ADC, 4 SBC, 5 CMPA, 6 CMPI, 7 BIT, 8 ASL, 9 LSR, 10 ROL, 11 ROR, 12 INC, 13 DEC, 14 AXS, 15 PASS.
- R2: AND, OR and XOR combine the accumulator with the operand. They set Z when the result is zero and N from result bit 7, and leave C and V as they were.
- R3: ADC returns the low byte of acc + operand + C. The new C is bit 8 of that sum. V is set when acc and operand have the same sign but the result's sign differs from acc. N and Z follow the result.
- R4: SBC returns acc − operand − (1 − C). The new C is 1 exactly when no borrow occurs. V is set when acc and operand differ in sign and the result's sign differs from acc. N and Z follow the result.
- R5: CMPA compares the accumulator with the operand, and CMPI compares the index input with the operand. Z and N are taken from the low byte of the difference, and C = (register ≥ operand, unsigned). V is unchanged, and the output byte equals the compared register.
- R6: BIT sets Z when (acc AND operand) is zero and copies operand bit 7 into N and operand bit 6 into V. C is unchanged, and the output byte equals acc.
- R7: ASL shifts the operand left and moves its bit 7 into C. LSR shifts it right, moves its bit 0 into C, and always leaves N clear. Z follows the result, and V is unchanged.
- R8: ROL shifts the old C in at bit 0 and takes the new C from operand bit 7. ROR shifts the old C in at bit 7 and takes the new C from operand bit 0. N and Z follow the result, and V is unchanged.
- R9: INC and DEC return operand ± 1, wrapping modulo 256. They update only N and Z and leave C and V unchanged.
- R10: AXS returns the low byte of (acc AND index) − operand, which is the new index value. N and Z follow that byte, C = ((acc AND index) ≥ operand), and V is unchanged.
- R11: PASS returns the operand unchanged and leaves all four flags as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (R1) |
| acc_i | input | 8 | Accumulator value |
| idx_i | input | 8 | Index register value (CMPI, AXS) |
| opnd_i | input | 8 | Operand byte |
| flags_i | input | 4 | Current flags {N,V,Z,C} |
| result_o | output | 8 | Result byte |
| flags_o | output | 4 | Updated flags {N,V,Z,C} |

## Verification
The cases hardest to hit are signed overflow in SBC and the exact boundary of the unsigned compare. In SBC, overflow depends jointly on the two operand signs and on the incoming borrow. In the compare, register equal to operand must give C=1 and Z=1, and a difference of one must give C=0. Uniform random bytes hit these cases only rarely. The stimulus therefore mixes a long seeded random run with directed vectors at 0x7F/0x80, 0x00/0xFF and equal operands, and with both values of the incoming carry.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_AND  = 4'd0,  OP_OR   = 4'd1,  OP_XOR  = 4'd2,  OP_ADC  = 4'd3,
    OP_SBC  = 4'd4,  OP_CMPA = 4'd5,  OP_CMPI = 4'd6,  OP_BIT  = 4'd7,
    OP_ASL  = 4'd8,  OP_LSR  = 4'd9,  OP_ROL  = 4'd10, OP_ROR  = 4'd11,
    OP_INC  = 4'd12, OP_DEC  = 4'd13, OP_AXS  = 4'd14, OP_PASS = 4'd15
  } alu_op_e;

  localparam int FL_N = 3;
  localparam int FL_V = 2;
  localparam int FL_Z = 1;
  localparam int FL_C = 0;
endpackage

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      default: res_o = a_i & b_i; // AND and BIT
    endcase
  end
endmodule

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             ci_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             co_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] full;
  assign full  = {1'b0, x_i} + {1'b0, y_i} + {{WIDTH{1'b0}}, ci_i};
  assign sum_o = full[MSB:0];
  assign co_o  = full[WIDTH];
  // signed overflow: like-signed inputs, sum sign differs
  assign ovf_o = (x_i[MSB] == y_i[MSB]) && (sum_o[MSB] != x_i[MSB]);
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             ci_i,
  output logic [WIDTH-1:0] res_o,
  output logic             co_o
);
  always_comb begin
    unique case (op_i)
      OP_ASL:  {co_o, res_o} = {b_i, 1'b0};
      OP_LSR:  {res_o, co_o} = {1'b0, b_i};
      OP_ROL:  {co_o, res_o} = {b_i, ci_i};
      OP_ROR:  {res_o, co_o} = {ci_i, b_i};
      default: begin
        res_o = b_i;
        co_o  = ci_i;
      end
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] idx_i,
  input  logic [WIDTH-1:0] opnd_i,
  input  logic [3:0]       flags_i,
  output logic [WIDTH-1:0] result_o,
  output logic [3:0]       flags_o
);
  localparam int MSB = WIDTH - 1;

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  // shared adder operand steering
  logic [WIDTH-1:0] add_x, add_y, add_sum;
  logic             add_ci, add_co, add_ovf;

  always_comb begin
    add_x  = acc_i;
    add_y  = ~opnd_i;        // subtract by default: x + ~y + ci
    add_ci = flags_i[FL_C];
    unique case (op)
      OP_ADC:  add_y = opnd_i;
      OP_CMPA: add_ci = 1'b1;
      OP_CMPI: begin add_x = idx_i;         add_ci = 1'b1; end
      OP_AXS:  begin add_x = acc_i & idx_i; add_ci = 1'b1; end
      OP_INC:  begin add_x = opnd_i; add_y = '0; add_ci = 1'b1; end
      OP_DEC:  begin add_x = opnd_i; add_y = '1; add_ci = 1'b0; end
      default: ;
    endcase
  end

  alu8_adder #(.WIDTH(WIDTH)) adder_i (
    .x_i  (add_x),
    .y_i  (add_y),
    .ci_i (add_ci),
    .sum_o(add_sum),
    .co_o (add_co),
    .ovf_o(add_ovf)
  );

  logic [WIDTH-1:0] log_res;
  alu8_logic #(.WIDTH(WIDTH)) logic_i (
    .op_i (op),
    .a_i  (acc_i),
    .b_i  (opnd_i),
    .res_o(log_res)
  );

  logic [WIDTH-1:0] sh_res;
  logic             sh_co;
  alu8_shift #(.WIDTH(WIDTH)) shift_i (
    .op_i (op),
    .b_i  (opnd_i),
    .ci_i (flags_i[FL_C]),
    .res_o(sh_res),
    .co_o (sh_co)
  );

  // result select and flag merge
  logic             zn_upd;
  logic [WIDTH-1:0] res;
  logic [3:0]       fl;

  always_comb begin
    res    = opnd_i;
    fl     = flags_i;
    zn_upd = 1'b0;
    unique case (op)
      OP_AND, OP_OR, OP_XOR: begin
        res    = log_res;
        zn_upd = 1'b1;
      end
      OP_ADC, OP_SBC: begin
        res      = add_sum;
        fl[FL_C] = add_co;
        fl[FL_V] = add_ovf;
        zn_upd   = 1'b1;
      end
      OP_CMPA, OP_CMPI: begin
        res      = (op == OP_CMPI) ? idx_i : acc_i;
        fl[FL_C] = add_co;
        fl[FL_Z] = (add_sum == '0);
        fl[FL_N] = add_sum[MSB];
      end
      OP_AXS: begin
        res      = add_sum;
        fl[FL_C] = add_co;
        zn_upd   = 1'b1;
      end
      OP_BIT: begin
        res      = acc_i;
        fl[FL_Z] = (log_res == '0);
        fl[FL_N] = opnd_i[MSB];
        fl[FL_V] = opnd_i[MSB-1];
      end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
        res      = sh_res;
        fl[FL_C] = sh_co;
        zn_upd   = 1'b1;
      end
      OP_INC, OP_DEC: begin
        res    = add_sum;
        zn_upd = 1'b1;
      end
      default: ;
    endcase
    if (zn_upd) begin
      fl[FL_Z] = (res == '0);
      fl[FL_N] = res[MSB];
    end
  end

  assign result_o = res;
  assign flags_o  = fl;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] acc_i,
  input logic [WIDTH-1:0] idx_i,
  input logic [WIDTH-1:0] opnd_i,
  input logic [3:0]       flags_i,
  input logic [WIDTH-1:0] result_o,
  input logic [3:0]       flags_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] adc_ref;
  logic [WIDTH:0] axs_ref;
  assign adc_ref = {1'b0, acc_i} + {1'b0, opnd_i} + {{WIDTH{1'b0}}, flags_i[FL_C]};
  assign axs_ref = {1'b0, acc_i & idx_i} - {1'b0, opnd_i};

  always_comb begin
    // R2 R3 R4: Z tracks a zero result for value-producing ops
    if (op_i inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd8, 4'd9, 4'd10, 4'd11, 4'd12, 4'd13, 4'd14})
      a_r2_zero_tracks_result: assert (flags_o[FL_Z] == (result_o == '0));
    if (op_i == 4'd3)
      a_r3_carry_sum: assert ({flags_o[FL_C], result_o} == adc_ref);
    if (op_i == 4'd9)
      a_r7_lsr_n_clear: assert (!flags_o[FL_N]);
    if (op_i == 4'd7)
      a_r6_bit_copies: assert (result_o == acc_i && flags_o[FL_N] == opnd_i[MSB]
                               && flags_o[FL_V] == opnd_i[MSB-1]
                               && flags_o[FL_C] == flags_i[FL_C]);
    if (op_i == 4'd12 || op_i == 4'd13)
      a_r9_incdec_keep_cv: assert (flags_o[FL_C] == flags_i[FL_C] && flags_o[FL_V] == flags_i[FL_V]);
    if (op_i == 4'd14)
      a_r10_axs_value: assert (result_o == axs_ref[MSB:0] && flags_o[FL_C] == !axs_ref[WIDTH]);
    if (op_i == 4'd15)
      a_r11_pass_through: assert (result_o == opnd_i && flags_o == flags_i);
  end
endmodule

bind alu8_core alu8_core_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  logic [3:0] op;
  logic [7:0] acc, idx, opnd, res;
  logic [3:0] fin, fout;

  alu8_core dut_i (
    .op_i(op), .acc_i(acc), .idx_i(idx), .opnd_i(opnd),
    .flags_i(fin), .result_o(res), .flags_o(fout)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic done = 1'b0;

  function automatic string tag(input logic [3:0] o);
    case (o)
      4'd0, 4'd1, 4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5, 4'd6: return "R5";
      4'd7: return "R6";
      4'd8, 4'd9: return "R7";
      4'd10, 4'd11: return "R8";
      4'd12, 4'd13: return "R9";
      4'd14: return "R10";
      default: return "R11";
    endcase
  endfunction

  // R1 flag packing {N,V,Z,C}
  function automatic logic [11:0] model(input logic [3:0] o, input logic [7:0] a,
                                        input logic [7:0] x, input logic [7:0] b,
                                        input logic [3:0] f);
    logic [8:0] t;
    logic [7:0] r, ax;
    logic n, v, z, c, c0, zn;
    {n, v, z, c} = f;
    c0 = c;
    r  = b;
    zn = 1'b1;
    ax = a & x;
    case (o)
      4'd0: r = a & b;
      4'd1: r = a | b;
      4'd2: r = a ^ b;
      4'd3: begin
        t = {1'b0, a} + {1'b0, b} + {8'd0, c0};
        r = t[7:0]; c = t[8];
        v = (a[7] == b[7]) && (r[7] != a[7]);
      end
      4'd4: begin
        t = {1'b0, a} - {1'b0, b} - {8'd0, ~c0};
        r = t[7:0]; c = ~t[8];
        v = (a[7] != b[7]) && (r[7] != a[7]);
      end
      4'd5, 4'd6: begin
        r  = (o == 4'd5) ? a : x;
        t  = {1'b0, r} - {1'b0, b};
        z  = (t[7:0] == 8'd0); n = t[7]; c = (r >= b);
        zn = 1'b0;
      end
      4'd7: begin
        r = a; z = ((a & b) == 8'd0); n = b[7]; v = b[6]; zn = 1'b0;
      end
      4'd8:  begin r = {b[6:0], 1'b0}; c = b[7]; end
      4'd9:  begin r = {1'b0, b[7:1]}; c = b[0]; end
      4'd10: begin r = {b[6:0], c0};   c = b[7]; end
      4'd11: begin r = {c0, b[7:1]};   c = b[0]; end
      4'd12: r = b + 8'd1;
      4'd13: r = b - 8'd1;
      4'd14: begin
        t = {1'b0, ax} - {1'b0, b};
        r = t[7:0]; c = (ax >= b);
      end
      default: zn = 1'b0;
    endcase
    if (zn) begin
      z = (r == 8'd0); n = r[7];
    end
    return {n, v, z, c, r};
  endfunction

  task automatic run(input logic [3:0] o, input logic [7:0] a, input logic [7:0] x,
                     input logic [7:0] b, input logic [3:0] f);
    logic [11:0] exp;
    @(negedge clk);
    op = o; acc = a; idx = x; opnd = b; fin = f;
    #2;
    exp = model(o, a, x, b, f);
    checks++;
    if ({fout, res} !== exp) begin
      fails++;
      $display("FAIL %s op=%0d a=%h x=%h b=%h f=%b actual=%h/%b expected=%h/%b",
               tag(o), o, a, x, b, f, res, fout, exp[7:0], exp[11:8]);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    op = 4'd15; acc = '0; idx = '0; opnd = '0; fin = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // R1 idle state: PASS with zero inputs
    run(4'd15, 8'h00, 8'h00, 8'h00, 4'b0000);
    run(4'd0, 8'h00, 8'h00, 8'h00, 4'b0000);  // R2 zero -> Z
    run(4'd2, 8'hF0, 8'h00, 8'h0F, 4'b0101);  // R2 N set, C/V kept
    run(4'd3, 8'h7F, 8'h00, 8'h01, 4'b0000);  // R3 V
    run(4'd3, 8'hFF, 8'h00, 8'h00, 4'b0001);  // R3 carry, zero
    run(4'd4, 8'h80, 8'h00, 8'h01, 4'b0001);  // R4 V
    run(4'd4, 8'h00, 8'h00, 8'h00, 4'b0000);  // R4 borrow in
    run(4'd5, 8'h42, 8'h00, 8'h42, 4'b0100);  // R5 equal
    run(4'd5, 8'h41, 8'h00, 8'h42, 4'b0001);  // R5 below
    run(4'd6, 8'h00, 8'h10, 8'h0F, 4'b0000);  // R5 index
    run(4'd7, 8'h0F, 8'h00, 8'hC0, 4'b0001);  // R6
    run(4'd9, 8'h00, 8'h00, 8'h01, 4'b1000);  // R7 LSR to zero
    run(4'd8, 8'h00, 8'h00, 8'h80, 4'b0000);  // R7 ASL carry
    run(4'd10, 8'h00, 8'h00, 8'h80, 4'b0001); // R8 ROL
    run(4'd11, 8'h00, 8'h00, 8'h01, 4'b0001); // R8 ROR
    run(4'd12, 8'h00, 8'h00, 8'hFF, 4'b0101); // R9 wrap
    run(4'd13, 8'h00, 8'h00, 8'h00, 4'b0000); // R9 wrap
    run(4'd14, 8'hF3, 8'h3C, 8'h30, 4'b0100); // R10 equal -> Z,C
    run(4'd14, 8'hF3, 8'h3C, 8'h31, 4'b0000); // R10 borrow
    run(4'd15, 8'h12, 8'h34, 8'hA5, 4'b1111); // R11
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] o;
      logic [7:0] a, b;
      o = 4'($urandom_range(0, 15));
      a = 8'($urandom);
      b = (i % 4 == 0) ? a : 8'($urandom);
      run(o, a, 8'($urandom), b, 4'($urandom));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule